// File: doc/BRIEF.md
# Six-Valued Static Hazard Evaluator

This block evaluates two-input logic on signals expressed in a six-valued algebra used to find static hazards. Each value is short for a three-sample waveform: the level before a change, the level at an unknown instant during the change, and the level after it. The three samples of each operand are combined one position at a time in three-valued logic, where u stands for "could be either". The resulting waveform is then mapped back to one of the six values. A result that starts and ends at the same level but may glitch in between is a static hazard, and a flag marks it.

A second path builds a six-valued code from a plain pair of levels, one before and one after. The middle sample is unknown when the two levels differ and equal to them when they match. This is how a primary input is entered into the algebra. Both paths feed one registered output stage that loads only while the enable is high, so the two results for one cycle appear together one cycle later.

Top module: `hzd6_eval`

## Requirements
- R1: Values are 3-bit codes: 0 = 3'd0 (000), 1 = 3'd1 (111), R = 3'd2 (0u1), F = 3'd3 (1u0), 0* = 3'd4 (0u0), 1* = 3'd5 (1u1). An operand code of 3'd6 or 3'd7 is handled exactly as 0*, and the result never carries 3'd6 or 3'd7.
- R2: `op_sel` picks the operation: 2'd0 AND, 2'd1 NAND, 2'd2 NOT (operand a only, b has no effect), 2'd3 AND.
- R3: AND with a 0 operand gives 0. AND of 0* with any value other than 0 gives 0*.
- R4: R AND R gives R, F AND F gives F, R AND F gives 0*. 1 and 1* leave R and F unchanged under AND. 1 AND 1 gives 1, 1 AND 1* gives 1*, and 1* AND 1* gives 1*.
- R5: NOT swaps 0 with 1, R with F and 0* with 1*. NAND equals NOT applied to the AND result.
- R6: `hazard_q` is high exactly when the registered gate result is 0* or 1*.
- R7: The waveform path maps (`wave_start`, `wave_end`) = (0,0) to 0, (1,1) to 1, (0,1) to R and (1,0) to F, and never yields 0* or 1*.
- R8: With `en` high, `res_q`, `hazard_q` and `wave_code_q` show the results for the inputs present at a rising clock edge from that edge on. With `en` low, all three hold their values.
- R9: While `rst_n` is low, and for two clocks after it rises, all outputs are 0 regardless of `en` and the data inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Load enable for the output registers |
| op_sel | input | 2 | Operation select (AND, NAND, NOT, AND) |
| opnd_a | input | 3 | First six-valued operand |
| opnd_b | input | 3 | Second six-valued operand |
| wave_start | input | 1 | Level before the change, for the waveform path |
| wave_end | input | 1 | Level after the change, for the waveform path |
| res_q | output | 3 | Registered six-valued gate result |
| hazard_q | output | 1 | Registered static-hazard flag for `res_q` |
| wave_code_q | output | 3 | Registered six-valued code of the level pair |

## Verification
The gate evaluation and the level-pair encoding load into the same register stage on the same enabled edge. A mismatch between the two paths would therefore show up as one output being correct and the other stale or swapped. The sweep drives a different level pair alongside every operand combination, so each of the four level pairs falls in the same cycle as AND, NAND and NOT results. All three outputs are compared in the cycle after each load. Enable-low cycles with changed inputs on both paths check that neither output moves.

// File: rtl/hzd6_pkg.sv
package hzd6_pkg;

  // six-valued codes
  localparam logic [2:0] HV_ZERO = 3'd0;
  localparam logic [2:0] HV_ONE  = 3'd1;
  localparam logic [2:0] HV_RISE = 3'd2;
  localparam logic [2:0] HV_FALL = 3'd3;
  localparam logic [2:0] HV_HZ0  = 3'd4;
  localparam logic [2:0] HV_HZ1  = 3'd5;

  // operation select
  localparam logic [1:0] OP_AND  = 2'd0;
  localparam logic [1:0] OP_NAND = 2'd1;
  localparam logic [1:0] OP_NOT  = 2'd2;
  localparam logic [1:0] OP_ALT  = 2'd3;

  // three-valued sample
  typedef logic [1:0] trit_t;
  localparam trit_t TR_LO  = 2'b00;
  localparam trit_t TR_HI  = 2'b01;
  localparam trit_t TR_UNK = 2'b10;

  // waveform: [2] before, [1] during, [0] after
  localparam int WPOS = 3;
  typedef logic [WPOS-1:0][1:0] wave_t;

  function automatic trit_t t_and(input trit_t x, input trit_t y);
    if (x == TR_LO || y == TR_LO)      return TR_LO;
    else if (x == TR_HI && y == TR_HI) return TR_HI;
    else                               return TR_UNK;
  endfunction

  function automatic trit_t t_not(input trit_t x);
    if (x == TR_LO)      return TR_HI;
    else if (x == TR_HI) return TR_LO;
    else                 return TR_UNK;
  endfunction

  function automatic trit_t t_lvl(input logic b);
    return b ? TR_HI : TR_LO;
  endfunction

endpackage

// File: rtl/hzd6_expand.sv
module hzd6_expand
  import hzd6_pkg::*;
(
  input  logic [2:0] code,
  output wave_t      wave
);

  always_comb begin
    case (code)
      HV_ZERO: wave = {TR_LO,  TR_LO,  TR_LO};
      HV_ONE:  wave = {TR_HI,  TR_HI,  TR_HI};
      HV_RISE: wave = {TR_LO,  TR_UNK, TR_HI};
      HV_FALL: wave = {TR_HI,  TR_UNK, TR_LO};
      HV_HZ1:  wave = {TR_HI,  TR_UNK, TR_HI};
      default: wave = {TR_LO,  TR_UNK, TR_LO}; // 0* and unused codes
    endcase
  end

endmodule

// File: rtl/hzd6_lanewise.sv
module hzd6_lanewise
  import hzd6_pkg::*;
(
  input  wave_t wa,
  input  wave_t wb,
  input  logic  pass_a,
  input  logic  invert,
  output wave_t wy
);

  for (genvar gp = 0; gp < WPOS; gp++) begin : g_pos
    trit_t lane_v;
    assign lane_v  = pass_a ? wa[gp] : t_and(wa[gp], wb[gp]);
    assign wy[gp]  = invert ? t_not(lane_v) : lane_v;
  end

endmodule

// File: rtl/hzd6_classify.sv
module hzd6_classify
  import hzd6_pkg::*;
(
  input  wave_t      wave,
  output logic [2:0] code
);

  trit_t s_beg, s_mid, s_end;
  logic  ends_known;

  assign s_beg      = wave[2];
  assign s_mid      = wave[1];
  assign s_end      = wave[0];
  assign ends_known = (s_beg == TR_LO || s_beg == TR_HI) &&
                      (s_end == TR_LO || s_end == TR_HI);

  always_comb begin
    code = HV_HZ0;
    if (ends_known) begin
      if (s_beg != s_end) begin
        // a known middle is promoted to u when the ends differ
        code = (s_beg == TR_LO) ? HV_RISE : HV_FALL;
      end else if (s_beg == TR_LO) begin
        code = (s_mid == TR_LO) ? HV_ZERO : HV_HZ0;
      end else begin
        code = (s_mid == TR_HI) ? HV_ONE : HV_HZ1;
      end
    end
  end

endmodule

// File: rtl/hzd6_eval.sv
module hzd6_eval
  import hzd6_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] op_sel,
  input  logic [2:0] opnd_a,
  input  logic [2:0] opnd_b,
  input  logic       wave_start,
  input  logic       wave_end,
  output logic [2:0] res_q,
  output logic       hazard_q,
  output logic [2:0] wave_code_q
);

  // reset: asserted at once, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  // gate path
  wave_t      wave_a, wave_b, wave_g, wave_lv;
  logic       pass_a, invert;
  logic [2:0] res_c, lvl_c;
  logic       hazard_c;

  assign pass_a = (op_sel == OP_NOT);
  assign invert = (op_sel == OP_NAND) || (op_sel == OP_NOT);

  hzd6_expand u_exp_a (.code(opnd_a), .wave(wave_a));
  hzd6_expand u_exp_b (.code(opnd_b), .wave(wave_b));

  hzd6_lanewise u_lane (
    .wa     (wave_a),
    .wb     (wave_b),
    .pass_a (pass_a),
    .invert (invert),
    .wy     (wave_g)
  );

  hzd6_classify u_cls_gate (.wave(wave_g), .code(res_c));

  assign hazard_c = (res_c == HV_HZ0) || (res_c == HV_HZ1);

  // level-pair path: a changing input is unknown in the middle
  assign wave_lv = {t_lvl(wave_start),
                    (wave_start == wave_end) ? t_lvl(wave_start) : TR_UNK,
                    t_lvl(wave_end)};

  hzd6_classify u_cls_lvl (.wave(wave_lv), .code(lvl_c));

  // output stage: next state
  logic [2:0] res_d, wcode_d;
  logic       hazard_d;

  always_comb begin
    res_d    = res_q;
    hazard_d = hazard_q;
    wcode_d  = wave_code_q;
    if (en) begin
      res_d    = res_c;
      hazard_d = hazard_c;
      wcode_d  = lvl_c;
    end
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q       <= HV_ZERO;
      hazard_q    <= 1'b0;
      wave_code_q <= HV_ZERO;
    end else begin
      res_q       <= res_d;
      hazard_q    <= hazard_d;
      wave_code_q <= wcode_d;
    end
  end

endmodule

// File: rtl/hzd6_eval_chk.sv
module hzd6_eval_chk
  import hzd6_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] op_sel,
  input logic [2:0] opnd_a,
  input logic [2:0] opnd_b,
  input logic       wave_start,
  input logic       wave_end,
  input logic [2:0] res_q,
  input logic       hazard_q,
  input logic [2:0] wave_code_q
);

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_q <= HV_HZ1);

  p_zero_dom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_sel == OP_AND || op_sel == OP_ALT) &&
     (opnd_a == HV_ZERO || opnd_b == HV_ZERO)) |=> res_q == HV_ZERO);

  p_hz0_absorb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_AND && opnd_a == HV_HZ0 && opnd_b != HV_ZERO)
      |=> res_q == HV_HZ0);

  p_not_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_NOT && opnd_a == HV_RISE) |=> res_q == HV_FALL);

  p_hazard_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_q == (res_q == HV_HZ0 || res_q == HV_HZ1));

  p_lvl_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wave_start && wave_end) |=> wave_code_q == HV_RISE);

  p_lvl_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wave_code_q <= HV_FALL);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_q) && $stable(hazard_q) && $stable(wave_code_q)));

endmodule

bind hzd6_eval hzd6_eval_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .en          (en),
  .op_sel      (op_sel),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .wave_start  (wave_start),
  .wave_end    (wave_end),
  .res_q       (res_q),
  .hazard_q    (hazard_q),
  .wave_code_q (wave_code_q)
);

// File: tb/hzd6_eval_test.sv
`timescale 1ns/1ps
module hzd6_eval_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] op_sel;
  logic [2:0] opnd_a, opnd_b;
  logic       wave_start, wave_end;
  logic [2:0] res_q, wave_code_q;
  logic       hazard_q;

  int n_vec  = 0;
  int n_miss = 0;

  always #2 clk = ~clk;

  hzd6_eval uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .wave_start(wave_start), .wave_end(wave_end),
    .res_q(res_q), .hazard_q(hazard_q), .wave_code_q(wave_code_q)
  );

  // expected values from the rules, codes 0..5 = 0,1,R,F,0*,1*
  function automatic int norm(input int c);
    return (c > 5) ? 4 : c;
  endfunction

  function automatic int inv(input int c);
    return (c % 2 == 0) ? c + 1 : c - 1;
  endfunction

  function automatic int exp_and(input int a0, input int b0);
    int a = norm(a0);
    int b = norm(b0);
    if (a == 0 || b == 0) return 0;
    if (a == 4 || b == 4) return 4;
    if (a == 1 || a == 5) begin
      if (b == 1) return a;
      return b;
    end
    if (b == 1 || b == 5) return a;
    return (a == b) ? a : 4;
  endfunction

  function automatic int exp_res(input int op, input int a, input int b);
    if (op == 1) return inv(exp_and(a, b));
    if (op == 2) return inv(norm(a));
    return exp_and(a, b);
  endfunction

  function automatic int exp_lvl(input int s, input int e);
    return (s == e) ? s : 2 + s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string gate_tag(input int op, input int a, input int b);
    if (op == 3)             return "R2";
    if (op == 1 || op == 2)  return "R5";
    if (a > 5 || b > 5)      return "R1";
    if (a == 0 || b == 0 || a == 4 || b == 4) return "R3";
    return "R4";
  endfunction

  task automatic apply(input int op, input int a, input int b,
                       input int s, input int e);
    int r;
    op_sel = 2'(op); opnd_a = 3'(a); opnd_b = 3'(b);
    wave_start = s[0]; wave_end = e[0]; en = 1'b1;
    @(posedge clk); @(negedge clk);
    r = exp_res(op, a, b);
    check(gate_tag(op, a, b), int'(res_q), r);
    check("R6", int'(hazard_q), (r >= 4) ? 1 : 0);
    check("R7", int'(wave_code_q), exp_lvl(s, e));
  endtask

  initial begin
    #800000;
    n_miss++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    int hold_r, hold_w;
    rst_n = 1'b0; en = 1'b1; op_sel = 2'd2; opnd_a = 3'd0; opnd_b = 3'd5;
    wave_start = 1'b0; wave_end = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset holds outputs at 0 even with en high and data present
    check("R9", int'(res_q), 0);
    check("R9", int'(hazard_q), 0);
    check("R9", int'(wave_code_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(res_q), 0);
    check("R9", int'(wave_code_q), 0);
    en = 1'b0;
    repeat (4) @(negedge clk);

    // full sweep: every op, every code pair, level pair varies alongside
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          apply(op, a, b, (a + b + op) % 2, ((a + b + op) / 2) % 2);

    // R2: NOT ignores operand b
    for (int b = 0; b < 8; b++) begin
      apply(2, 2, b, 1, 0);
      check("R2", int'(res_q), 3);
    end

    // R8: enable low holds outputs while both paths' inputs change
    for (int k = 0; k < 6; k++) begin
      apply(0, 2, 3, k % 2, (k + 1) % 2);
      hold_r = int'(res_q);
      hold_w = int'(wave_code_q);
      en = 1'b0; op_sel = 2'd2; opnd_a = 3'(k % 2); opnd_b = 3'd1;
      wave_start = 1'b1; wave_end = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R8", int'(res_q), hold_r);
      check("R8", int'(hazard_q), 1);
      check("R8", int'(wave_code_q), hold_w);
    end

    // R9: asynchronous reset clears outputs mid-run
    apply(1, 1, 1, 1, 0);
    rst_n = 1'b0;
    #1;
    check("R9", int'(res_q), 0);
    check("R9", int'(wave_code_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(0, 5, 5, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule